// File: doc/BRIEF.md
# Frequent Value Bus Encoder

This block sits on the transmit side of a wide external data bus and rewrites each outgoing word so that fewer wires toggle. It keeps a small table of recently seen values. A word found in the table goes out as a one-hot pointer to its table slot. Any other word goes out unchanged. Before it reaches the pins, each result is XORed with the word already on the bus, so a table hit moves exactly one wire.

Two refinements sit on top of this. First, a word equal to the previous input bypasses the table and leaves the bus as it is, so the receiver's XOR yields zero. Slot 0 is permanently bound to the value zero, which means a zero XOR can only mean a repeat. Second, small values from 1 up to a threshold are never stored, because their raw form already has few bits set. A skip line tells the receiver when a raw word happens to look like a one-hot code.

Table slots are filled and replaced by a recency scheme. Each slot has a reference bit and a short history of timestamp bits, and that history is shifted at a fixed count of accepted words. A receiving decoder that follows the same rules keeps an identical table.

Top module: `fv_bus_encoder`

## Requirements
- R1: After reset, busOut and skipOut are 0, lastVal is 0, and every slot other than slot 0 is empty (invalid, reference bit 0, timestamp 0). inReady is always 1.
- R2: A non-repeat word that matches valid slot i (i from 1 to WIDTH-1) drives busOut to the previous busOut XOR (1 << i), with skipOut 0. The slot's reference bit is then set.
- R3: A non-repeat word that matches no slot drives busOut to the previous busOut XOR the word.
- R4: A word equal to the previous accepted word (lastVal, which is 0 after reset) leaves busOut unchanged and drives skipOut to 0. Table contents and reference bits are not updated.
- R5: Slot 0 always holds the value 0. A non-repeat zero word toggles bus bit 0 only.
- R6: skipOut is 1 after a non-repeat word that is sent raw and has exactly one bit set. After every other accepted word, skipOut is 0.
- R7: Words from 1 to EXCL_MAX (16 by default) are never written into the table, so they are always sent raw.
- R8: A non-repeat miss on an eligible word (nonzero and above EXCL_MAX) writes the word into a victim slot among 1..WIDTH-1 and gives that slot reference bit 1 and timestamp 0. The victim is the slot with the smallest key {refBit, timestamp}. Empty slots count as key 0. On a tie, the lowest index wins.
- R9: Every AGE_PERIOD accepted words, repeats included, all slots age: each timestamp shifts right by one with the reference bit entering the MSB, and then the reference bits clear. In that same cycle, the current word's hit or insert is applied after the aging step.
- R10: A word accepted on one clock edge appears on busOut/skipOut right after that edge. With no accepted word, busOut holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Always high; one word accepted per cycle |
| inData | input | WIDTH | Word to transmit |
| busOut | output | WIDTH | Registered encoded bus word |
| skipOut | output | 1 | Registered skip-decode control line |

## Verification
The bench builds the encoder with WIDTH 32, TS_BITS 3, EXCL_MAX 16, and AGE_PERIOD reduced from 1024 to 8. The short aging period lets timestamps shift many times within a few thousand words, so aged keys decide real evictions rather than every slot sitting at key zero. A pool of 64 distinct values, including small excluded ones, overfills the 31 replaceable slots. This forces the victim ordering and tie-breaking to be exercised, and the output is compared every cycle against an independent table model.

// File: rtl/fv_pkg.sv
package fv_pkg;
  // per-cycle strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic repeatWord;
    logic hit;
    logic insert;
    logic ageTick;
  } fvStrobe_t;
endpackage

// File: rtl/fv_ctrl.sv
module fv_ctrl
  import fv_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int TS_BITS    = 3,
  parameter int AGE_PERIOD = 1024,
  parameter int EXCL_MAX   = 16,
  localparam int ENTRIES   = WIDTH,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int CNT_W     = $clog2(AGE_PERIOD)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   inData,
  input  logic [WIDTH-1:0]   lastVal,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] entryRef,
  input  logic [TS_BITS-1:0] entryTs [ENTRIES],
  output fvStrobe_t          stb,
  output logic [IDX_W-1:0]   victimIdx
);

  logic [CNT_W-1:0]   ageCnt;
  logic               excluded;
  logic [TS_BITS:0]   bestKey;
  logic [TS_BITS:0]   curKey;

  assign excluded = (inData >= WIDTH'(1)) && (inData <= WIDTH'(EXCL_MAX));

  always_comb begin
    stb.accept     = inValid;
    stb.repeatWord = inValid && (inData == lastVal);
    stb.hit        = inValid && !stb.repeatWord && (|matchVec);
    stb.insert     = inValid && !stb.repeatWord && !(|matchVec) && !excluded;
    stb.ageTick    = inValid && (ageCnt == CNT_W'(AGE_PERIOD - 1));
  end

  // smallest {ref, ts}; strict compare keeps the lowest index on ties
  always_comb begin
    victimIdx = IDX_W'(1);
    bestKey   = {entryRef[1], entryTs[1]};
    curKey    = '0;
    for (int i = 2; i < ENTRIES; i++) begin
      curKey = {entryRef[i], entryTs[i]};
      if (curKey < bestKey) begin
        bestKey   = curKey;
        victimIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCnt <= '0;
    end else if (inValid) begin
      ageCnt <= (ageCnt == CNT_W'(AGE_PERIOD - 1)) ? '0 : ageCnt + CNT_W'(1);
    end
  end

  // R8
  victim_not_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.insert |-> (victimIdx != '0));

  // R9
  tick_wraps_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ageTick |=> (ageCnt == '0));

endmodule

// File: rtl/fv_datapath.sv
module fv_datapath
  import fv_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int TS_BITS  = 3,
  parameter int EXCL_MAX = 16,
  localparam int ENTRIES = WIDTH,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fvStrobe_t          stb,
  input  logic [IDX_W-1:0]   victimIdx,
  input  logic [WIDTH-1:0]   inData,
  output logic [WIDTH-1:0]   lastVal,
  output logic [ENTRIES-1:0] matchVec,
  output logic [ENTRIES-1:0] entryRef,
  output logic [TS_BITS-1:0] entryTs [ENTRIES],
  output logic [WIDTH-1:0]   busOut,
  output logic               skipOut
);

  logic [WIDTH-1:0]   entryVal [ENTRIES];
  logic [ENTRIES-1:0] entryValid;
  logic [TS_BITS:0]   refTs    [ENTRIES];
  logic [WIDTH-1:0]   code;
  logic               rawOneHot;

  // slot 0 is the hardwired zero
  always_comb begin
    matchVec[0] = (inData == '0);
    for (int i = 1; i < ENTRIES; i++) begin
      matchVec[i] = entryValid[i] && (entryVal[i] == inData);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      refTs[i] = {entryRef[i], entryTs[i]};
    end
  end

  assign code      = stb.hit ? matchVec : inData;
  assign rawOneHot = !stb.hit && ($countones(inData) == 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entryVal[i] <= '0;
        entryTs[i]  <= '0;
      end
      entryValid <= '0;
      entryRef   <= '0;
    end else if (stb.accept) begin
      for (int i = 1; i < ENTRIES; i++) begin
        if (stb.insert && (victimIdx == IDX_W'(i))) begin
          entryVal[i]   <= inData;
          entryValid[i] <= 1'b1;
          entryRef[i]   <= 1'b1;
          entryTs[i]    <= '0;
        end else begin
          if (stb.ageTick) begin
            entryTs[i]  <= refTs[i][TS_BITS:1];
            entryRef[i] <= 1'b0;
          end
          if (stb.hit && matchVec[i]) entryRef[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOut  <= '0;
      skipOut <= 1'b0;
      lastVal <= '0;
    end else if (stb.accept) begin
      lastVal <= inData;
      if (stb.repeatWord) begin
        skipOut <= 1'b0;
      end else begin
        busOut  <= busOut ^ code;
        skipOut <= rawOneHot;
      end
    end
  end

  // R2
  hit_one_wire_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.hit |=> ($countones(busOut ^ $past(busOut)) == 1));

  // R4
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && stb.repeatWord) |=> ($stable(busOut) && !skipOut));

  // R5
  nonrepeat_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && !stb.repeatWord) |=> (busOut != $past(busOut)));

  // R6
  skip_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept |=> (!skipOut || ($countones(busOut ^ $past(busOut)) == 1)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.accept |=> $stable(busOut));

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  for (genvar g = 1; g < ENTRIES; g++) begin : gEntryChk
    // R7
    no_small_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      entryValid[g] |-> (entryVal[g] > WIDTH'(EXCL_MAX)));
  end

endmodule

// File: rtl/fv_bus_encoder.sv
module fv_bus_encoder
  import fv_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int TS_BITS    = 3,
  parameter int AGE_PERIOD = 1024,
  parameter int EXCL_MAX   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] busOut,
  output logic             skipOut
);

  localparam int ENTRIES = WIDTH;
  localparam int IDX_W   = $clog2(ENTRIES);

  fvStrobe_t          stb;
  logic [IDX_W-1:0]   victimIdx;
  logic [WIDTH-1:0]   lastVal;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] entryRef;
  logic [TS_BITS-1:0] entryTs [ENTRIES];

  assign inReady = 1'b1;

  fv_ctrl #(
    .WIDTH(WIDTH), .TS_BITS(TS_BITS), .AGE_PERIOD(AGE_PERIOD), .EXCL_MAX(EXCL_MAX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .lastVal(lastVal), .matchVec(matchVec), .entryRef(entryRef),
    .entryTs(entryTs), .stb(stb), .victimIdx(victimIdx)
  );

  fv_datapath #(
    .WIDTH(WIDTH), .TS_BITS(TS_BITS), .EXCL_MAX(EXCL_MAX)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .victimIdx(victimIdx), .inData(inData),
    .lastVal(lastVal), .matchVec(matchVec), .entryRef(entryRef),
    .entryTs(entryTs), .busOut(busOut), .skipOut(skipOut)
  );

endmodule

// File: tb/test_fv_bus_encoder.sv
module test_fv_bus_encoder;
  localparam int W    = 32;
  localparam int N    = 32;
  localparam int AGEP = 8;
  localparam int EXM  = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] inData = '0;
  logic [W-1:0] busOut;
  logic         skipOut;

  int checks = 0;
  int failures = 0;
  bit accFlag = 1'b0;
  bit done = 1'b0;

  logic [W-1:0] qBus[$];
  bit           qSkip[$];
  string        qTag[$];

  // independent table model
  logic [W-1:0] mVal [N];
  bit           mValid [N];
  bit           mRef [N];
  logic [2:0]   mTs [N];
  logic [W-1:0] mBus;
  logic [W-1:0] mLast;
  int           mCnt;

  always #2.5 clk = ~clk;

  fv_bus_encoder #(.WIDTH(W), .TS_BITS(3), .AGE_PERIOD(AGEP), .EXCL_MAX(EXM))
    i_fv_bus_encoder (.clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
                      .inData(inData), .busOut(busOut), .skipOut(skipOut));

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic [W-1:0] w, output logic [W-1:0] eb, output bit es);
    bit rep;
    int hitI;
    int vic;
    bit tick;
    bit ins;
    logic [3:0] best;
    rep  = (w == mLast);
    hitI = -1;
    if (!rep) begin
      if (w == '0) hitI = 0;
      else for (int i = 1; i < N; i++) if (mValid[i] && mVal[i] == w) hitI = i;
    end
    ins = !rep && hitI < 0 && !(w >= 1 && w <= EXM);
    vic = 1;
    best = {mRef[1], mTs[1]};
    for (int i = 2; i < N; i++) if ({mRef[i], mTs[i]} < best) begin
      best = {mRef[i], mTs[i]};
      vic = i;
    end
    tick = (mCnt == AGEP - 1);
    mCnt = tick ? 0 : mCnt + 1;
    if (!rep) begin
      if (tick) for (int i = 1; i < N; i++) begin
        mTs[i]  = {mRef[i], mTs[i][2:1]};
        mRef[i] = 1'b0;
      end
      if (hitI > 0) mRef[hitI] = 1'b1;
      if (ins) begin
        mVal[vic] = w; mValid[vic] = 1'b1; mRef[vic] = 1'b1; mTs[vic] = '0;
      end
      eb = mBus ^ ((hitI >= 0) ? (W'(1) << hitI) : w);
      es = (hitI < 0) && ($countones(w) == 1);
    end else begin
      if (tick) for (int i = 1; i < N; i++) begin
        mTs[i]  = {mRef[i], mTs[i][2:1]};
        mRef[i] = 1'b0;
      end
      eb = mBus;
      es = 1'b0;
    end
    mBus  = eb;
    mLast = w;
  endtask

  // driver: called at a negedge; pushes expectation, drives one cycle
  task automatic send(input logic [W-1:0] w, input bit useExp, input logic [W-1:0] expBus,
                      input bit expSkip, input string tag);
    logic [W-1:0] eb;
    bit es;
    modelStep(w, eb, es);
    qBus.push_back(useExp ? expBus : eb);
    qSkip.push_back(useExp ? expSkip : es);
    qTag.push_back(tag);
    inValid = 1'b1;
    inData  = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  always @(posedge clk) accFlag <= inValid && rstN;

  // monitor
  always @(negedge clk) begin
    if (accFlag && qBus.size() > 0) begin
      logic [W-1:0] eb;
      bit es;
      string t;
      eb = qBus.pop_front();
      es = qSkip.pop_front();
      t  = qTag.pop_front();
      check(busOut === eb, {t, " bus"}, busOut, eb);
      check(skipOut === es, {t, " skip"}, W'(skipOut), W'(es));
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mVal[i] = '0; mValid[i] = 1'b0; mRef[i] = 1'b0; mTs[i] = '0;
    end
    mBus = '0; mLast = '0; mCnt = 0;
    repeat (3) @(negedge clk);
    // R1
    check(busOut === '0, "R1 reset bus", busOut, '0);
    check(skipOut === 1'b0, "R1 reset skip", W'(skipOut), '0);
    check(inReady === 1'b1, "R1 ready", W'(inReady), W'(1));
    rstN = 1'b1;
    @(negedge clk);
    send(32'h0, 1, 32'h0, 0, "R4 zero after reset repeats");
    send(32'h12345678, 1, 32'h12345678, 0, "R3 raw miss");
    send(32'h0, 1, 32'h12345679, 0, "R5 hardwired zero");
    send(32'h12345678, 1, 32'h1234567B, 0, "R2 hit slot1");
    send(32'h12345678, 1, 32'h1234567B, 0, "R4 repeat");
    send(32'h4, 1, 32'h1234567F, 1, "R6 R7 small one-hot raw");
    send(32'h4, 1, 32'h1234567F, 0, "R4 R6 repeat skip low");
    send(32'h7, 1, 32'h12345678, 0, "R7 small raw");
    send(32'h4, 1, 32'h1234567C, 1, "R7 small never stored");
    send(32'h80000000, 1, 32'h9234567C, 1, "R6 R8 raw one-hot insert");
    send(32'h12345678, 1, 32'h9234567E, 0, "R9 aged slot1 still hits");
    send(32'h80000000, 1, 32'h9234567A, 0, "R8 victim slot2");
    repeat (3) @(negedge clk);
    // R10
    check(busOut === 32'h9234567A, "R10 idle hold", busOut, 32'h9234567A);
    for (int k = 0; k < 3000; k++) begin
      int idx;
      logic [W-1:0] v;
      idx = $urandom_range(0, 63);
      v = (idx < 8) ? W'(idx) : (32'h0100_0000 + W'(idx) * 32'h0001_0203);
      send(v, 0, '0, 0, "R8 R9 model");
      if ((k % 97) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule